// File: doc/BRIEF.md
# Lockable Security Control Register

This block holds a 32-bit control word that drives privileged enables in the rest of the chip. Software reaches it over a simple word-wide register bus with a byte address, a write strobe, write data and read data that follows the address in the same cycle. A 5-bit lock register sits beside the control word. Each lock bit freezes its own group of control fields. Once a lock bit is set it stays set until reset.

A third location takes an unlock key. The correct key leaves everything unchanged. Any other value is treated as an attack: it clears the top privilege bit of the control word and the 3-bit mode field, except where those fields are already frozen by a lock. Part of the control word is hard read-only and always keeps its reset value.

The block also watches the 3-bit mode field. If a control write leaves that field neither all-zeros nor all-ones, the block raises a sticky error flag, which only reset clears. The whole control word is presented as an output so that downstream logic can use it directly.

Top module: `lockable_ctrl_reg`

## Requirements
- R1: After reset the control word is 0x0C006000 (bits 27, 26, 14 and 13 set), the lock register is 0 and the error flag is low.
- R2: A write to the lock register at offset 0x04 ORs write-data bits 4:0 into it. A lock bit is never cleared except by reset. Bits 31:5 of the lock register read as zero and ignore writes.
- R3: Lock-to-field mapping on a control write at offset 0x00: lock bit 0 freezes control bits 6:0, bit 1 freezes bit 7, bit 2 freezes bit 8, bit 3 freezes bits 11:9, and bit 4 freezes bit 12. A frozen field keeps its previous value, and unlocked fields take the written data.
- R4: Control bits in mask 0x107F6000 are read-only and keep their reset values on every write. Writable bits outside any locked group take the written data.
- R5: A write to the unlock register at offset 0x34 with any value other than 0x757BDF0D clears control bit 27, and clears bits 11:9 unless lock bit 3 is set. All other control bits are unchanged.
- R6: A write of exactly 0x757BDF0D to offset 0x34 leaves the control word unchanged. Reads of offset 0x34 return zero.
- R7: If a control write leaves bits 11:9 at a value other than 000 or 111, the error flag goes high on the next clock edge and stays high until reset.
- R8: Reads of any offset other than 0x00, 0x04 and 0x34 return zero. Read data at 0x00 and 0x04 equals the current control and lock values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ctrl_q | output | 32 | Current control word |
| lock_q | output | 5 | Current lock bits |
| cfg_err | output | 1 | Sticky flag for an inconsistent mode field |

## Verification
Some internal faults show up only in certain cases. A wrong lock-group mask shows up as a frozen field that moves, or a free field that sticks. This is visible on ctrl_q one cycle after the control write, but only when that lock bit is set and the written data differs from the held value. A lock register that loses bits shows on lock_q the cycle after a write of zero. A key comparator that is off by one bit shows as bit 27 dropping after the correct key. The error flag is checked on the cycle after each mode-field write and again after later clean writes, to catch a flag that is not sticky.

// File: rtl/lcr_pkg.sv
package lcr_pkg;

  parameter int DATA_W = 32;
  parameter int ADDR_W = 8;
  parameter int LOCK_W = 5;

  parameter logic [ADDR_W-1:0] OFF_CTRL   = 8'h00;
  parameter logic [ADDR_W-1:0] OFF_LOCK   = 8'h04;
  parameter logic [ADDR_W-1:0] OFF_UNLOCK = 8'h34;

  parameter logic [DATA_W-1:0] CTRL_RST   = 32'h0C00_6000;
  parameter logic [DATA_W-1:0] RO_MASK    = 32'h107F_6000;
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h757B_DF0D;

  // mode field that must be uniform and that a bad key wipes
  parameter int MODE_LSB = 9;
  parameter int MODE_W   = 3;
  parameter int PRIV_BIT = 27;

  localparam logic [DATA_W-1:0] MODE_MASK = ((DATA_W'(1) << MODE_W) - 1) << MODE_LSB;
  localparam logic [DATA_W-1:0] ZAP_MASK  = MODE_MASK | (DATA_W'(1) << PRIV_BIT);

  // control bits guarded by one lock bit
  function automatic logic [DATA_W-1:0] lock_group_mask(input int unsigned idx);
    logic [DATA_W-1:0] m;
    case (idx)
      0:       m = DATA_W'(32'h0000_007F);
      1:       m = DATA_W'(32'h0000_0080);
      2:       m = DATA_W'(32'h0000_0100);
      3:       m = MODE_MASK;
      4:       m = DATA_W'(32'h0000_1000);
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic mode_uniform(input logic [MODE_W-1:0] f);
    return (f == '0) || (f == '1);
  endfunction

  // merge written data with the bits that must hold
  function automatic logic [DATA_W-1:0] merge_keep(input logic [DATA_W-1:0] old_v,
                                                   input logic [DATA_W-1:0] new_v,
                                                   input logic [DATA_W-1:0] keep);
    return (old_v & keep) | (new_v & ~keep);
  endfunction

endpackage

// File: rtl/lcr_addr_dec.sv
module lcr_addr_dec #(
  parameter int ADDR_W = lcr_pkg::ADDR_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              sel_ctrl,
  output logic              sel_lock,
  output logic              sel_unlock,
  output logic              ctrl_wr,
  output logic              lock_wr,
  output logic              unlock_wr
);
  always_comb begin
    sel_ctrl   = (addr == lcr_pkg::OFF_CTRL);
    sel_lock   = (addr == lcr_pkg::OFF_LOCK);
    sel_unlock = (addr == lcr_pkg::OFF_UNLOCK);
    ctrl_wr    = we && sel_ctrl;
    lock_wr    = we && sel_lock;
    unlock_wr  = we && sel_unlock;
  end
endmodule

// File: rtl/lcr_lock_bank.sv
module lcr_lock_bank #(
  parameter int DATA_W = lcr_pkg::DATA_W,
  parameter int LOCK_W = lcr_pkg::LOCK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock_wr,
  input  logic [LOCK_W-1:0] lock_set,
  output logic [LOCK_W-1:0] lock_q,
  output logic [DATA_W-1:0] locked_mask
);
  logic [DATA_W-1:0] grp_term [LOCK_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= '0;
    else if (lock_wr) lock_q <= lock_q | lock_set;
  end

  for (genvar g = 0; g < LOCK_W; g++) begin : g_grp
    assign grp_term[g] = lock_q[g] ? lcr_pkg::lock_group_mask(g) : '0;
  end

  always_comb begin
    locked_mask = '0;
    for (int g = 0; g < LOCK_W; g++) locked_mask = locked_mask | grp_term[g];
  end
endmodule

// File: rtl/lcr_key_cmp.sv
module lcr_key_cmp #(
  parameter int DATA_W = lcr_pkg::DATA_W
) (
  input  logic              unlock_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic              key_bad,
  output logic              bad_evt
);
  always_comb begin
    key_bad = (wdata != lcr_pkg::UNLOCK_KEY);
    bad_evt = unlock_wr && key_bad;
  end
endmodule

// File: rtl/lcr_ctrl_core.sv
module lcr_ctrl_core #(
  parameter int DATA_W = lcr_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic              bad_evt,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] locked_mask,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              cfg_err,
  output logic              incons_evt
);
  import lcr_pkg::*;

  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] wr_val;
  logic [DATA_W-1:0] zap_val;

  always_comb begin
    keep_mask  = RO_MASK | locked_mask;
    wr_val     = merge_keep(ctrl_q, wdata, keep_mask);
    zap_val    = ctrl_q & ~(ZAP_MASK & ~locked_mask);
    incons_evt = ctrl_wr && !mode_uniform(wr_val[MODE_LSB +: MODE_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RST;
    else if (ctrl_wr) ctrl_q <= wr_val;
    else if (bad_evt) ctrl_q <= zap_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg_err <= 1'b0;
    else if (incons_evt) cfg_err <= 1'b1;
  end
endmodule

// File: rtl/lockable_ctrl_reg.sv
module lockable_ctrl_reg #(
  parameter int DATA_W = lcr_pkg::DATA_W,
  parameter int ADDR_W = lcr_pkg::ADDR_W,
  parameter int LOCK_W = lcr_pkg::LOCK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [LOCK_W-1:0] lock_q,
  output logic              cfg_err
);
  logic              sel_ctrl, sel_lock, sel_unlock;
  logic              ctrl_wr, lock_wr, unlock_wr;
  logic              key_bad, bad_evt, incons_evt;
  logic [DATA_W-1:0] locked_mask;

  lcr_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .we(bus_we),
    .sel_ctrl(sel_ctrl), .sel_lock(sel_lock), .sel_unlock(sel_unlock),
    .ctrl_wr(ctrl_wr), .lock_wr(lock_wr), .unlock_wr(unlock_wr)
  );

  lcr_lock_bank #(.DATA_W(DATA_W), .LOCK_W(LOCK_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .lock_wr(lock_wr),
    .lock_set(bus_wdata[LOCK_W-1:0]),
    .lock_q(lock_q), .locked_mask(locked_mask)
  );

  lcr_key_cmp #(.DATA_W(DATA_W)) u_key (
    .unlock_wr(unlock_wr), .wdata(bus_wdata),
    .key_bad(key_bad), .bad_evt(bad_evt)
  );

  lcr_ctrl_core #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .bad_evt(bad_evt),
    .wdata(bus_wdata), .locked_mask(locked_mask),
    .ctrl_q(ctrl_q), .cfg_err(cfg_err), .incons_evt(incons_evt)
  );

  // the unlock location reads as zero, like unmapped space
  always_comb begin
    bus_rdata = '0;
    if (sel_ctrl)      bus_rdata = ctrl_q;
    else if (sel_lock) bus_rdata = DATA_W'(lock_q);
  end
endmodule

// File: rtl/lcr_checker.sv
module lcr_checker #(
  parameter int DATA_W = lcr_pkg::DATA_W,
  parameter int ADDR_W = lcr_pkg::ADDR_W,
  parameter int LOCK_W = lcr_pkg::LOCK_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [LOCK_W-1:0] lock_q,
  input logic              cfg_err,
  input logic [DATA_W-1:0] locked_mask,
  input logic              unlock_wr,
  input logic              key_bad
);
  import lcr_pkg::*;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock_q & $past(lock_q)) == $past(lock_q))); // R2

  AST_LOCK_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFF_LOCK) |-> (bus_rdata[DATA_W-1:LOCK_W] == '0)); // R2

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (((ctrl_q ^ $past(ctrl_q)) & $past(locked_mask)) == '0)); // R3

  AST_RO_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_q & RO_MASK) == (CTRL_RST & RO_MASK))); // R4

  AST_BAD_KEY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_wr && key_bad) |=> !ctrl_q[PRIV_BIT]); // R5

  AST_GOOD_KEY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_wr && !key_bad) |=> $stable(ctrl_q)); // R6

  AST_ERR_ON_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == OFF_CTRL) |=> (mode_uniform(ctrl_q[MODE_LSB +: MODE_W]) || cfg_err)); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_err) |-> cfg_err); // R7
endmodule

bind lockable_ctrl_reg lcr_checker chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_rdata(bus_rdata), .ctrl_q(ctrl_q), .lock_q(lock_q), .cfg_err(cfg_err),
  .locked_mask(locked_mask), .unlock_wr(unlock_wr), .key_bad(key_bad)
);

// File: tb/lockable_ctrl_reg_tb_top.sv
`timescale 1ns/1ps
module lockable_ctrl_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, ctrl_q;
  logic [4:0]  lock_q;
  logic        cfg_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lockable_ctrl_reg dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_q(ctrl_q),
    .lock_q(lock_q), .cfg_err(cfg_err)
  );

  function automatic logic [31:0] grp(input int i);
    case (i)
      0: return 32'h0000_007F;
      1: return 32'h0000_0080;
      2: return 32'h0000_0100;
      3: return 32'h0000_0E00;
      default: return 32'h0000_1000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; bus_we = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    chk("R1 ctrl", ctrl_q, 32'h0C00_6000);
    chk("R1 lock", 32'(lock_q), 32'h0);
    chk("R1 err", 32'(cfg_err), 32'h0);
    rd(8'h00, v); chk("R8 read ctrl", v, 32'h0C00_6000);
  endtask

  task automatic t_ro_mask();
    do_reset();
    wr(8'h00, 32'hFFFF_FFFF);
    chk("R4 all ones", ctrl_q, 32'hEF80_FFFF);
    wr(8'h00, 32'h0000_0000);
    chk("R4 all zeros", ctrl_q, 32'h0000_6000);
    chk("R7 uniform no err", 32'(cfg_err), 32'h0);
  endtask

  task automatic t_lock_sticky();
    logic [31:0] v;
    do_reset();
    wr(8'h04, 32'hFFFF_FFE1);
    rd(8'h04, v); chk("R2 upper ignored", v, 32'h1);
    wr(8'h04, 32'h0);
    chk("R2 sticky", 32'(lock_q), 32'h1);
    wr(8'h04, 32'h4);
    chk("R2 or", 32'(lock_q), 32'h5);
  endtask

  task automatic t_lock_map();
    for (int i = 0; i < 5; i++) begin
      do_reset();
      wr(8'h00, 32'h0000_1FFF);
      wr(8'h04, 32'(1) << i);
      wr(8'h00, 32'h0);
      chk($sformatf("R3 group %0d", i), ctrl_q, 32'h6000 | grp(i));
      chk($sformatf("R7 group %0d err", i), 32'(cfg_err), 32'h0);
    end
  endtask

  task automatic t_bad_key();
    do_reset();
    wr(8'h00, 32'h0800_6E00);
    wr(8'h34, 32'h1234_5678);
    chk("R5 bad key unlocked", ctrl_q, 32'h0000_6000);
    do_reset();
    wr(8'h00, 32'h0800_6E00);
    wr(8'h04, 32'h1F);
    wr(8'h34, 32'h757B_DF0C);
    chk("R5 bad key mode locked", ctrl_q, 32'h0000_6E00);
  endtask

  task automatic t_good_key();
    logic [31:0] v;
    do_reset();
    wr(8'h00, 32'h0800_6E00);
    wr(8'h34, 32'h757B_DF0D);
    chk("R6 good key", ctrl_q, 32'h0800_6E00);
    rd(8'h34, v); chk("R6 unlock reads zero", v, 32'h0);
  endtask

  task automatic t_incons();
    do_reset();
    wr(8'h00, 32'h0000_0200);
    chk("R7 ctrl value", ctrl_q, 32'h0000_6200);
    chk("R7 err set", 32'(cfg_err), 32'h1);
    wr(8'h00, 32'h0000_0000);
    chk("R7 err sticky", 32'(cfg_err), 32'h1);
    wr(8'h34, 32'h0);
    chk("R7 err sticky after key", 32'(cfg_err), 32'h1);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    do_reset();
    wr(8'h04, 32'h3);
    rd(8'h08, v); chk("R8 unmapped 08", v, 32'h0);
    rd(8'h30, v); chk("R8 unmapped 30", v, 32'h0);
    rd(8'h04, v); chk("R8 read lock", v, 32'h3);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_ro_mask();
    t_lock_sticky();
    t_lock_map();
    t_bad_key();
    t_good_key();
    t_incons();
    t_unmapped();
    finish_run();
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule